// File: doc/BRIEF.md
# Lockable Watchdog and Interval Timer

This block counts prescaler ticks in an 8-bit counter and, each time the count wraps, reports the event in one of three ways. It can raise a held maskable interrupt flag, which makes it a periodic interval timer. It can send a one-cycle non-maskable interrupt pulse. It can send a one-cycle reset request. Software controls it through a single 8-bit control register on a plain write/read bus. That register holds a start bit and a two-bit routing field, and software can only set these bits, never clear them. Once software has started the count or armed a watchdog routing, only a hardware reset can undo it.

Software keeps a watchdog from firing by writing the start bit again. Each such write returns the count to zero. A free-running prescaler keeps running through these restarts, so a restart never changes the tick phase. A 3-bit select input picks the tick period, which is 2^sel clock cycles. If software arms the non-maskable routing while an interval flag is still pending, the block issues a non-maskable pulse immediately.

Top module: `wdt_ivt`

## Requirements
- R1: After reset, a read at the register address (default 9) returns 0x00. A read always returns bit 7 = start bit, bits 4:3 = routing field, and zero in all other bits. A read at any other address returns 0x00. All three event outputs are low after reset.
- R2: While the start bit is 0, the counter does not advance and no event output asserts, whatever the routing field holds.
- R3: Any register write with bit 7 = 1 sets the start bit and returns the count to zero, so the next wrap comes a full 256 ticks later. A write with bit 7 = 0 leaves the start bit at 1 and does not disturb the count.
- R4: Routing bits 4 and 3 are set-only. A write of 1 sets a bit. A write of 0 leaves it unchanged.
- R5: With select = 0 (one tick per cycle), the first wrap takes effect at the 256th clock edge after the edge that captures the start write.
- R6: The routing field {bit4,bit3} selects the wrap event. 00 and 01 set the maskable flag. 10 gives a one-cycle non-maskable pulse. 11 gives a one-cycle reset request. No other event output moves.
- R7: The maskable flag stays high until the clear input is sampled high, and then it drops one cycle later.
- R8: If a write sets bit 4 while bit 4 was 0 and the maskable flag is high, a one-cycle non-maskable pulse follows on the next cycle.
- R9: The prescaler is never reset by a start write. With select = s, a wrap follows a start write after between 255*2^s+1 and 256*2^s cycles.
- R10: A write changes the register only when the write strobe is high and the address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| clk_sel | input | 3 | Prescaler tap select, tick period 2^clk_sel cycles |
| irq_clr | input | 1 | Clears the maskable interrupt flag |
| irq_flag | output | 1 | Held maskable interrupt request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A corrupted count shows up as a wrap event that arrives at the wrong cycle. With one tick per cycle, the bench sees that at an exact cycle number 256 cycles after a start write, so an off-by-one is caught within one period. A start bit or routing bit that can be cleared shows up at once when the register is read back after a write of zeros. A wrong routing field sends the wrap to the wrong one of the three outputs, and the bench catches that at the first wrap. A prescaler that resets on a start write shifts the wrap timing out of the allowed window for a slow tap.

// File: rtl/wdt_ivt.sv
module wdt_ivt #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 3,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              irq_clr,
  output logic              irq_flag,
  output logic              nmi_pulse,
  output logic              rst_req
);
  localparam int PRE_W = (1 << SEL_W);
  localparam logic [ADDR_W-1:0] HIT_ADDR = REG_ADDR[ADDR_W-1:0];

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [1:0]       mode_q;

  logic [PRE_W-1:0] tap_mask;
  logic             wr_hit, start, tick, wrap, arm_nmi;

  assign tap_mask = (PRE_W'(1) << clk_sel) - PRE_W'(1);
  assign wr_hit   = bus_wr && (bus_addr == HIT_ADDR);
  assign start    = wr_hit && bus_wdata[7];
  assign tick     = run_q && ((pre_q & tap_mask) == tap_mask);
  assign wrap     = tick && (cnt_q == '1) && !start;
  assign arm_nmi  = wr_hit && bus_wdata[4] && !mode_q[1] && irq_flag;

  assign bus_rdata = (bus_addr == HIT_ADDR) ? {run_q, 2'b00, mode_q, 3'b000} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      run_q  <= run_q | start;
      mode_q <= mode_q | (wr_hit ? bus_wdata[4:3] : 2'b00);
      if (start)     cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      nmi_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (wrap && !mode_q[1]) irq_flag <= 1'b1;
      else if (irq_clr)       irq_flag <= 1'b0;
      nmi_pulse <= (wrap && mode_q == 2'b10) || arm_nmi;
      rst_req   <= wrap && mode_q == 2'b11;
    end
  end

  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  p_mode4_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |=> mode_q[1]);
  p_mode3_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |=> mode_q[0]);
  p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0) && !irq_flag && !nmi_pulse && !rst_req);
  p_rst_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(mode_q) == 2'b11);
  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !wrap) |=> !irq_flag);
  p_rdata_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6:5] == 2'b00) && (bus_rdata[2:0] == 3'b000));
endmodule

// File: tb/tb_wdt_ivt.sv
module tb_wdt_ivt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'd9;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] clk_sel = 3'd0;
  logic       irq_clr = 1'b0;
  logic       irq_flag, nmi_pulse, rst_req;

  int checks = 0;
  int fails  = 0;
  bit seen_f, seen_n, seen_r;

  always #2 clk = ~clk;

  wdt_ivt dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
    .irq_clr(irq_clr), .irq_flag(irq_flag), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; irq_clr = 1'b0; clk_sel = 3'd0; bus_addr = 4'd9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'd9;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // which: 0 flag, 1 nmi, 2 reset request; n = -1 if not seen within limit
  task automatic wait_ev(input int which, input int limit, output int n);
    n = -1; seen_f = 0; seen_n = 0; seen_r = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      seen_f |= irq_flag; seen_n |= nmi_pulse; seen_r |= rst_req;
      if ((which == 0 && irq_flag) || (which == 1 && nmi_pulse) || (which == 2 && rst_req)) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(bus_rdata == 8'h00, "R1 reset read", bus_rdata, 0);
    chk({irq_flag, nmi_pulse, rst_req} == 3'b000, "R1 reset outputs", {irq_flag, nmi_pulse, rst_req}, 0);
    bus_addr = 4'd2; #0.1;
    chk(bus_rdata == 8'h00, "R1 other address read", bus_rdata, 0);
    bus_addr = 4'd9;
  endtask

  task automatic t_stopped();
    int n;
    do_reset();
    wr(4'd9, 8'h7F);
    chk(bus_rdata == 8'h18, "R1 field layout", bus_rdata, 8'h18);
    wait_ev(0, 600, n);
    chk(!seen_f && !seen_n && !seen_r, "R2 no event while stopped", {seen_f, seen_n, seen_r}, 0);
    wr(4'd9, 8'h00);
    chk(bus_rdata == 8'h18, "R4 routing bits set-only", bus_rdata, 8'h18);
  endtask

  task automatic t_interval();
    int n;
    do_reset();
    wr(4'd9, 8'h80);
    chk(bus_rdata == 8'h80, "R1 start bit read", bus_rdata, 8'h80);
    wait_ev(0, 400, n);
    chk(n == 256, "R5 first wrap at 256 ticks", n, 256);
    chk(!seen_n && !seen_r, "R6 mode 00 flag only", {seen_n, seen_r}, 0);
    idle(10);
    chk(irq_flag == 1'b1, "R7 flag held", irq_flag, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R7 flag cleared", irq_flag, 0);
  endtask

  task automatic t_sticky_run();
    int n;
    do_reset();
    wr(4'd9, 8'h80);
    idle(100);
    wr(4'd9, 8'h00);
    chk(bus_rdata == 8'h80, "R3 start bit stays set", bus_rdata, 8'h80);
    wait_ev(0, 400, n);
    chk(n == 155, "R3 zero write keeps count", n, 155);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    idle(50);
    wr(4'd9, 8'h80);
    wait_ev(0, 400, n);
    chk(n == 256, "R3 restart write reloads count", n, 256);
  endtask

  task automatic t_routing();
    int n;
    do_reset();
    wr(4'd9, 8'h88);
    wait_ev(0, 400, n);
    chk(n == 256 && !seen_n && !seen_r, "R6 mode 01 flag", n, 256);
    do_reset();
    wr(4'd9, 8'h90);
    chk(nmi_pulse == 1'b0, "R8 no arm pulse without flag", nmi_pulse, 0);
    wait_ev(1, 400, n);
    chk(n == 256 && !seen_f && !seen_r, "R6 mode 10 nmi", n, 256);
    @(negedge clk);
    chk(nmi_pulse == 1'b0, "R6 nmi one cycle", nmi_pulse, 0);
    do_reset();
    wr(4'd9, 8'h98);
    wait_ev(2, 400, n);
    chk(n == 256 && !seen_f && !seen_n, "R6 mode 11 reset request", n, 256);
    @(negedge clk);
    chk(rst_req == 1'b0, "R6 reset request one cycle", rst_req, 0);
  endtask

  task automatic t_arm_nmi();
    int n;
    do_reset();
    wr(4'd9, 8'h88);
    wait_ev(0, 400, n);
    wr(4'd9, 8'h10);
    chk(nmi_pulse == 1'b1, "R8 pending flag gives nmi", nmi_pulse, 1);
    @(negedge clk);
    chk(nmi_pulse == 1'b0, "R8 nmi one cycle", nmi_pulse, 0);
    chk(bus_rdata == 8'h98, "R4 routing bits accumulate", bus_rdata, 8'h98);
  endtask

  task automatic t_addr();
    int n;
    do_reset();
    wr(4'd3, 8'h98);
    chk(bus_rdata == 8'h00, "R10 wrong address ignored", bus_rdata, 0);
    bus_addr = 4'd9; bus_wdata = 8'h98; @(negedge clk);
    chk(bus_rdata == 8'h00, "R10 no strobe ignored", bus_rdata, 0);
    wait_ev(0, 300, n);
    chk(!seen_f && !seen_n && !seen_r, "R10 timer stays stopped", {seen_f, seen_n, seen_r}, 0);
  endtask

  task automatic t_prescale();
    int n;
    do_reset();
    clk_sel = 3'd2;
    idle(1);
    wr(4'd9, 8'h80);
    wait_ev(0, 1200, n);
    chk(n >= 1021 && n <= 1024, "R9 wrap window sel 2", n, 1024);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    idle(2);
    wr(4'd9, 8'h80);
    wait_ev(0, 1200, n);
    chk(n >= 1021 && n <= 1024, "R9 wrap window after restart", n, 1024);
  endtask

  initial begin
    t_reset();
    t_stopped();
    t_interval();
    t_sticky_run();
    t_routing();
    t_arm_nmi();
    t_addr();
    t_prescale();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule